// File: doc/BRIEF.md
# Two-Partition Frequency/Recency Replacement Engine

This block manages the metadata of a small fully associative content store that holds two groups of entries. A protected group is kept in recency order. An open group is ranked by a small saturating use counter. Requests carry a content key and are either a lookup or an insert. The engine reports whether the key is present, updates recency and use counts, and promotes an open entry that becomes popular into the protected group. It stores only keys and metadata; payload data lives elsewhere and is indexed by the caller.

An insert of a key that is not present runs a fixed three-step move. First, the lowest-ranked open entry is removed and its key is reported. Next, the least recent protected entry moves into the freed open slot. Last, the new key takes the freed protected slot as its most recent entry. The engine takes one request at a time and holds `busy` high until its response.

The controller has six states. `ST_IDLE` accepts a request (IDLE→CMP). `ST_CMP` compares the key against both groups. On a hit or a lookup it goes to `ST_RESP` (CMP→RESP); on an insert miss it goes to `ST_EVICT` (CMP→EVICT). `ST_EVICT` picks the victim and the least recent protected slot (EVICT→DEMOTE). `ST_DEMOTE` moves the protected entry down (DEMOTE→PLACE). `ST_PLACE` writes the new key (PLACE→RESP). `ST_RESP` presents the response for one cycle (RESP→IDLE).

Top module: `lfru_engine`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `evict_valid` are low, and both groups are empty, so any lookup misses.
- R2: A request is taken only while `busy` is low. `busy` stays high from the cycle after acceptance through the response cycle. A request presented while `busy` is high is ignored and changes no content.
- R3: A lookup responds with `resp_valid` high for one cycle, in the second cycle after acceptance. `resp_hit` is 1 exactly when the key is held in either group, and a missed lookup changes no content.
- R4: An insert of a key already held is reported as a hit in the second cycle after acceptance. It causes no eviction.
- R5: An insert of an absent key responds in the fifth cycle after acceptance with `resp_hit` 0. The removed open entry's key appears on `evict_key` with `evict_valid` high when that slot held a key. The least recent protected entry is moved into that slot with a use count of 1, and the new key becomes the most recent protected entry.
- R6: The open slot to remove is the lowest-indexed empty slot if any exists. Otherwise it is the slot with the smallest use count, with ties going to the lowest index.
- R7: A protected hit, a placement or a promotion makes that protected entry the most recent. The least recent protected entry is the one demoted.
- R8: A hit in the open group raises its use count by 1. When the raised count is at least a nonzero `promo_thr`, the entry swaps with the least recent protected entry, and the demoted entry starts with a use count of 1.
- R9: A `promo_thr` of 0 disables promotion; open entries then stay in the open group however often they hit.
- R10: When a raised use count reaches its maximum value (all ones), every open use count is halved, rounding down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_insert | input | 1 | 1 = insert, 0 = lookup |
| req_key | input | KEY_W | Content key of the request |
| promo_thr | input | CNT_W | Promotion threshold; 0 disables promotion |
| busy | output | 1 | A request is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Key was present (valid with `resp_valid`) |
| evict_valid | output | 1 | A held key was removed (valid with `resp_valid`) |
| evict_key | output | KEY_W | Key of the removed entry |

## Verification
The bench builds the engine with two protected slots, three open slots, 8-bit keys and 3-bit counters. With these values the store fills after five inserts, and a counter reaches saturation after a handful of lookups. The test sequence tunes the use counts so that halving turns a 3-versus-2 order into a 1-versus-1 tie. The tie then goes to the lower index, so the removed key shows whether aging took place. Promotion is shown through later evictions: a promoted entry, or the protected entry it displaced with a count of 1, is the next to leave.

// File: rtl/lfru_pkg.sv
package lfru_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_EVICT,
        ST_DEMOTE,
        ST_PLACE,
        ST_RESP
    } lfru_state_e;
endpackage

// File: rtl/lfru_cam.sv
// Key comparison across one group; reports the lowest matching slot.
module lfru_cam #(
    parameter int N    = 4,
    parameter int KW   = 16,
    parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [N-1:0]         vld,
    input  logic [KW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (keys[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/lfru_lru_find.sv
// Locates the protected slot whose recency age is the oldest.
module lfru_lru_find #(
    parameter int N  = 4,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][AW-1:0] ages,
    output logic [AW-1:0]        idx
);
    localparam logic [AW-1:0] OLDEST = AW'(N - 1);

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (ages[i] == OLDEST) idx = AW'(i);
        end
    end
endmodule

// File: rtl/lfru_victim.sv
// Ranks open slots: empty first, then smallest count, ties to lowest index.
module lfru_victim #(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][CW-1:0] cnt,
    output logic [IW-1:0]        idx
);
    logic [N-1:0][CW:0] score;
    logic [CW:0]        best;

    for (genvar g = 0; g < N; g++) begin : g_score
        assign score[g] = vld[g] ? {1'b1, cnt[g]} : '0;
    end

    always_comb begin
        idx  = '0;
        best = score[0];
        for (int i = 1; i < N; i++) begin
            if (score[i] < best) begin
                best = score[i];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lfru_engine.sv
module lfru_engine
    import lfru_pkg::*;
#(
    parameter int P_WAYS = 4,
    parameter int U_WAYS = 8,
    parameter int KEY_W  = 16,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_insert,
    input  logic [KEY_W-1:0] req_key,
    input  logic [CNT_W-1:0] promo_thr,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             evict_valid,
    output logic [KEY_W-1:0] evict_key
);
    localparam int PI_W = (P_WAYS > 1) ? $clog2(P_WAYS) : 1;
    localparam int UI_W = (U_WAYS > 1) ? $clog2(U_WAYS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lfru_state_e state_q, state_d;

    logic [P_WAYS-1:0][KEY_W-1:0] p_key;
    logic [P_WAYS-1:0]            p_vld;
    logic [P_WAYS-1:0][PI_W-1:0]  p_age;
    logic [U_WAYS-1:0][KEY_W-1:0] u_key;
    logic [U_WAYS-1:0]            u_vld;
    logic [U_WAYS-1:0][CNT_W-1:0] u_cnt;

    logic [KEY_W-1:0] key_q;
    logic             ins_q, hit_q, evv_q;
    logic [KEY_W-1:0] evk_q;
    logic [UI_W-1:0]  vict_q;
    logic [PI_W-1:0]  lru_q;

    logic             p_hit, u_hit;
    logic [PI_W-1:0]  p_idx, lru_idx, touch_idx;
    logic [UI_W-1:0]  u_idx, vict_idx;
    logic [CNT_W-1:0] inc_cnt;
    logic             saturate, promote, cmp_u, touch_en;

    lfru_cam #(.N(P_WAYS), .KW(KEY_W), .IW(PI_W)) u_pcam (
        .keys(p_key), .vld(p_vld), .key(key_q), .hit(p_hit), .idx(p_idx));
    lfru_cam #(.N(U_WAYS), .KW(KEY_W), .IW(UI_W)) u_ucam (
        .keys(u_key), .vld(u_vld), .key(key_q), .hit(u_hit), .idx(u_idx));
    lfru_lru_find #(.N(P_WAYS), .AW(PI_W)) u_lru (
        .ages(p_age), .idx(lru_idx));
    lfru_victim #(.N(U_WAYS), .CW(CNT_W), .IW(UI_W)) u_vict (
        .vld(u_vld), .cnt(u_cnt), .idx(vict_idx));

    // Use-count arithmetic and recency update selection
    always_comb begin
        inc_cnt  = (u_cnt[u_idx] == CNT_MAX) ? CNT_MAX : u_cnt[u_idx] + CNT_ONE;
        saturate = (inc_cnt == CNT_MAX);
        promote  = (promo_thr != '0) && (inc_cnt >= promo_thr);
        cmp_u    = (state_q == ST_CMP) && !p_hit && u_hit;
        touch_en  = 1'b0;
        touch_idx = lru_q;
        if (state_q == ST_CMP && p_hit) begin
            touch_en  = 1'b1;
            touch_idx = p_idx;
        end else if (cmp_u && promote) begin
            touch_en  = 1'b1;
            touch_idx = lru_idx;
        end else if (state_q == ST_PLACE) begin
            touch_en  = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CMP;
            ST_CMP:    state_d = (p_hit || u_hit || !ins_q) ? ST_RESP : ST_EVICT;
            ST_EVICT:  state_d = ST_DEMOTE;
            ST_DEMOTE: state_d = ST_PLACE;
            ST_PLACE:  state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        resp_valid  = (state_q == ST_RESP);
        resp_hit    = resp_valid && hit_q;
        evict_valid = resp_valid && evv_q;
        evict_key   = evk_q;
    end

    // Key and metadata storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < P_WAYS; i++) begin
                p_key[i] <= '0;
                p_vld[i] <= 1'b0;
                p_age[i] <= PI_W'(i);
            end
            for (int j = 0; j < U_WAYS; j++) begin
                u_key[j] <= '0;
                u_vld[j] <= 1'b0;
                u_cnt[j] <= '0;
            end
            key_q  <= '0;
            ins_q  <= 1'b0;
            hit_q  <= 1'b0;
            evv_q  <= 1'b0;
            evk_q  <= '0;
            vict_q <= '0;
            lru_q  <= '0;
        end else begin
            if (touch_en) begin
                for (int i = 0; i < P_WAYS; i++) begin
                    if (PI_W'(i) == touch_idx)          p_age[i] <= '0;
                    else if (p_age[i] < p_age[touch_idx]) p_age[i] <= p_age[i] + 1'b1;
                end
            end
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    key_q <= req_key;
                    ins_q <= req_insert;
                    hit_q <= 1'b0;
                    evv_q <= 1'b0;
                end
                ST_CMP: begin
                    hit_q <= p_hit || u_hit;
                    if (cmp_u) begin
                        for (int j = 0; j < U_WAYS; j++) begin
                            if (saturate && UI_W'(j) != u_idx) u_cnt[j] <= u_cnt[j] >> 1;
                        end
                        if (promote) begin
                            u_key[u_idx]   <= p_key[lru_idx];
                            u_vld[u_idx]   <= p_vld[lru_idx];
                            u_cnt[u_idx]   <= CNT_ONE;
                            p_key[lru_idx] <= u_key[u_idx];
                            p_vld[lru_idx] <= 1'b1;
                        end else begin
                            u_cnt[u_idx] <= saturate ? (inc_cnt >> 1) : inc_cnt;
                        end
                    end
                end
                ST_EVICT: begin
                    vict_q <= vict_idx;
                    lru_q  <= lru_idx;
                    evv_q  <= u_vld[vict_idx];
                    evk_q  <= u_key[vict_idx];
                end
                ST_DEMOTE: begin
                    u_key[vict_q] <= p_key[lru_q];
                    u_vld[vict_q] <= p_vld[lru_q];
                    u_cnt[vict_q] <= p_vld[lru_q] ? CNT_ONE : '0;
                end
                ST_PLACE: begin
                    p_key[lru_q] <= key_q;
                    p_vld[lru_q] <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lfru_engine_chk.sv
module lfru_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic resp_valid,
    input logic resp_hit,
    input logic evict_valid
);
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R2

    AST_BUSY_HOLDS_UNTIL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !resp_valid) |=> busy); // R2

    AST_RESP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && !busy)); // R3

    AST_EVICT_NEVER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> !resp_hit); // R5

    AST_EVICT_AFTER_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(busy, 3)); // R5
endmodule

bind lfru_engine lfru_engine_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .busy(busy),
    .resp_valid(resp_valid),
    .resp_hit(resp_hit),
    .evict_valid(evict_valid)
);

// File: tb/lfru_engine_tb.sv
`timescale 1ns/1ps
module lfru_engine_tb;
    localparam int KW = 8;
    localparam int CW = 3;
    localparam int NV = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_insert = 1'b0;
    logic [KW-1:0] req_key = '0;
    logic [CW-1:0] promo_thr = '0;
    logic          busy, resp_valid, resp_hit, evict_valid;
    logic [KW-1:0] evict_key;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lfru_engine #(.P_WAYS(2), .U_WAYS(3), .KEY_W(KW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insert(req_insert),
        .req_key(req_key), .promo_thr(promo_thr), .busy(busy),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .evict_valid(evict_valid), .evict_key(evict_key));

    // {req tag[3:0], insert, key[7:0], thr[2:0], exp hit, exp evict, exp evict key[7:0]}
    localparam logic [25:0] VEC [NV] = '{
        {4'd1, 1'b0, 8'h11, 3'd3, 1'b0, 1'b0, 8'h00}, // R1 empty store misses
        {4'd5, 1'b1, 8'h11, 3'd3, 1'b0, 1'b0, 8'h00}, // R5 fill
        {4'd5, 1'b1, 8'h22, 3'd3, 1'b0, 1'b0, 8'h00},
        {4'd6, 1'b1, 8'h33, 3'd3, 1'b0, 1'b0, 8'h00}, // R6 empty slots used first
        {4'd6, 1'b1, 8'h44, 3'd3, 1'b0, 1'b0, 8'h00},
        {4'd6, 1'b1, 8'h55, 3'd3, 1'b0, 1'b0, 8'h00},
        {4'd8, 1'b0, 8'h11, 3'd3, 1'b1, 1'b0, 8'h00}, // R8 count 2, below threshold
        {4'd8, 1'b0, 8'h22, 3'd3, 1'b1, 1'b0, 8'h00},
        {4'd6, 1'b1, 8'h66, 3'd3, 1'b0, 1'b1, 8'h33}, // R6 smallest count leaves
        {4'd3, 1'b0, 8'h33, 3'd3, 1'b0, 1'b0, 8'h00}, // R3 miss
        {4'd7, 1'b0, 8'h55, 3'd3, 1'b1, 1'b0, 8'h00}, // R7 protected hit
        {4'd4, 1'b1, 8'h66, 3'd3, 1'b1, 1'b0, 8'h00}, // R4 present key insert
        {4'd8, 1'b0, 8'h11, 3'd3, 1'b1, 1'b0, 8'h00}, // R8 reaches 3, promoted
        {4'd6, 1'b1, 8'h77, 3'd3, 1'b0, 1'b1, 8'h55}, // R6 tie to lowest index
        {4'd9, 1'b0, 8'h66, 3'd0, 1'b1, 1'b0, 8'h00}, // R9 no promotion
        {4'd9, 1'b0, 8'h66, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd9, 1'b0, 8'h44, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd10, 1'b0, 8'h22, 3'd0, 1'b1, 1'b0, 8'h00}, // R10 drive to saturation
        {4'd10, 1'b0, 8'h22, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd10, 1'b0, 8'h22, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd10, 1'b0, 8'h22, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd10, 1'b0, 8'h22, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd10, 1'b1, 8'h88, 3'd0, 1'b0, 1'b1, 8'h66}, // R10 halving makes a tie
        {4'd5, 1'b0, 8'h11, 3'd0, 1'b1, 1'b0, 8'h00},  // R5 demoted entry kept
        {4'd7, 1'b0, 8'h88, 3'd0, 1'b1, 1'b0, 8'h00},
        {4'd7, 1'b1, 8'h99, 3'd0, 1'b0, 1'b1, 8'h44},  // R7 oldest protected demoted
        {4'd8, 1'b0, 8'h77, 3'd2, 1'b1, 1'b0, 8'h00},  // R8 promote at threshold 2
        {4'd8, 1'b1, 8'hAA, 3'd2, 1'b0, 1'b1, 8'h88},  // R8 demoted count 1 leaves
        {4'd8, 1'b0, 8'h77, 3'd2, 1'b1, 1'b0, 8'h00},
        {4'd3, 1'b0, 8'h33, 3'd2, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input int rq, input logic ins, input logic [KW-1:0] key,
                         input logic [CW-1:0] thr, input logic ehit, input logic eev,
                         input logic [KW-1:0] ekey);
        int n;
        int lat;
        req_valid  = 1'b1;
        req_insert = ins;
        req_key    = key;
        promo_thr  = thr;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!resp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        lat = (ins && !ehit) ? 5 : 2;
        check(n == lat, rq, "latency", n, lat);
        check(resp_hit == ehit, rq, "hit", resp_hit, ehit);
        check(evict_valid == eev, rq, "evict_valid", evict_valid, eev);
        if (eev) check(evict_key == ekey, rq, "evict_key", evict_key, ekey);
        @(negedge clk);
        check(!busy, rq, "busy after response", busy, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy, 1, "busy at reset", busy, 0);
        check(!resp_valid, 1, "resp_valid at reset", resp_valid, 0);
        check(!evict_valid, 1, "evict_valid at reset", evict_valid, 0);

        for (int i = 0; i < NV; i++) begin
            do_op(int'(VEC[i][25:22]), VEC[i][21], VEC[i][20:13], VEC[i][12:10],
                  VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // R2: request presented while busy is ignored
        req_valid  = 1'b1;
        req_insert = 1'b1;
        req_key    = 8'hB1;
        promo_thr  = 3'd2;
        @(negedge clk);
        req_key = 8'hC2;
        for (int k = 1; k < 5; k++) begin
            check(busy, 2, "busy during insert", busy, 1);
            check(!resp_valid, 2, "early response", resp_valid, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(resp_valid, 2, "insert response", resp_valid, 1);
        check(evict_valid && evict_key == 8'h99, 6, "evict during busy test", evict_key, 8'h99);
        @(negedge clk);
        check(!resp_valid, 2, "no second response", resp_valid, 0);
        do_op(2, 1'b0, 8'hC2, 3'd2, 1'b0, 1'b0, 8'h00); // R2 ignored key absent
        do_op(5, 1'b0, 8'hB1, 3'd2, 1'b1, 1'b0, 8'h00); // R5 new key present

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule